// File: doc/BRIEF.md
# SPI Slave-Select Sequencer

This block owns the active-low slave-select line of an SPI master. It works in one of two modes. In software mode the line simply copies a level bit that firmware writes. In automatic mode the block drives the line low around every packet that the shift engine runs. Between packets it raises the line and keeps it high for a programmable minimum number of clock cycles.

The shift engine asks to start a packet with `pkt_start`. The request is taken only in a cycle where `ready` is high, and it is dropped otherwise. The engine reports the cycle that carries the last bit with `pkt_end`. The sequencer samples its mode input only while no packet is running. A mode change made during a packet therefore takes effect at the next packet boundary.

Top module: `spi_cs_seq`

## Requirements
- R1: After reset `cs_n` is 1, the active mode is software mode and `ready` is 1.
- R2: In software mode (`auto_mode` = 0), `cs_n` takes the value of `sw_level` at the next clock edge, where 1 means deselected and 0 means selected.
- R3: In automatic mode (`auto_mode` = 1), a start accepted in cycle t drives `cs_n` low from the edge that ends cycle t. It stays low through the cycle in which `pkt_end` is high and returns to 1 at the edge that ends that cycle.
- R4: In automatic mode `sw_level` has no effect on `cs_n` or `ready`.
- R5: In automatic mode, while idle, `ready` is 1 only when `cs_n` is 1 and the line has been high for at least `gap_count` cycles, the current cycle included. The line therefore stays high for at least max(`gap_count`,1) cycles between two packets.
- R6: With `gap_count` = 0 in automatic mode, `ready` is already 1 in the first cycle that the line is high, which gives a one-cycle gap.
- R7: While a packet is running (from an accepted start up to and including its `pkt_end` cycle), changes on `auto_mode` are ignored. The mode in use when the start was accepted controls `cs_n` until the packet ends.
- R8: A `pkt_start` made while `ready` is 0 is dropped. It does not change `cs_n` and does not start a packet.
- R9: In software mode `ready` is 1 exactly when no packet is running.
- R10: When automatic mode is entered after the line has been high for longer than `gap_count` cycles, `ready` is 1 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 selects automatic per-packet select, 0 selects software level |
| sw_level | input | 1 | Select level used in software mode |
| gap_count | input | CNT_W | Minimum number of high cycles between packets in automatic mode |
| pkt_start | input | 1 | Shift engine asks to start a packet; taken only while `ready` is 1 |
| pkt_end | input | 1 | Shift engine marks the cycle of the last bit of the running packet |
| cs_n | output | 1 | Active-low slave select |
| ready | output | 1 | A new packet may start in this cycle |

## Verification
The assertions assume that `pkt_end` is raised only while a packet is running and never in the same cycle as an accepted start. They also assume that the inputs stay stable around the clock edge. The bench changes its inputs only on the falling edge. Its shift-engine stand-in raises `pkt_end` only when its own reference model shows a packet in progress. `pkt_start`, `sw_level`, `auto_mode` and `gap_count` are left free, so a start made while `ready` is low and a mode change during a packet both occur.

// File: rtl/spi_cs_seq_pkg.sv
package spi_cs_seq_pkg;

   typedef enum logic {
      SEL_SW   = 1'b0,
      SEL_AUTO = 1'b1
   } sel_mode_e;

   function automatic logic line_level(input logic selected);
      return ~selected;
   endfunction

endpackage

// File: rtl/spi_cs_seq_mode.sv
module spi_cs_seq_mode
   import spi_cs_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      auto_req,
   input  logic      start_acc,
   input  logic      pkt_end,
   output logic      busy_o,
   output sel_mode_e mode_o,
   output sel_mode_e eff_o
);

   logic      busy_q;
   sel_mode_e mode_q;
   sel_mode_e eff;

   // the mode is sampled only outside a packet
   always_comb begin
      eff = busy_q ? mode_q : sel_mode_e'(auto_req);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= SEL_SW;
         busy_q <= 1'b0;
      end else begin
         mode_q <= eff;
         if (start_acc) begin
            busy_q <= 1'b1;
         end else if (pkt_end) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy_o = busy_q;
   assign mode_o = mode_q;
   assign eff_o  = eff;

endmodule

// File: rtl/spi_cs_seq_gap.sv
module spi_cs_seq_gap #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_hi,
   input  logic [CNT_W-1:0] gap_cfg,
   output logic             gap_met
);

   localparam int CMP_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 1 || CNT_W > 24) begin : g_bad_width
         $error("spi_cs_seq_gap: CNT_W out of range");
      end
   endgenerate

   // cycles the line has already been high before the current one
   logic [CNT_W-1:0] hi_q;
   logic [CMP_W-1:0] hi_incl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= CNT_MAX;
      end else if (!line_hi) begin
         hi_q <= '0;
      end else if (hi_q != CNT_MAX) begin
         hi_q <= hi_q + 1'b1;
      end
   end

   always_comb begin
      hi_incl = {1'b0, hi_q} + CMP_W'(1);
      gap_met = hi_incl >= {1'b0, gap_cfg};
   end

endmodule

// File: rtl/spi_cs_seq_line.sv
module spi_cs_seq_line
   import spi_cs_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  sel_mode_e eff,
   input  logic      start_acc,
   input  logic      busy,
   input  logic      pkt_end,
   input  logic      sw_level,
   output logic      cs_n_o
);

   logic cs_q;
   logic cs_d;

   always_comb begin
      if (eff == SEL_SW) begin
         cs_d = sw_level;
      end else if (start_acc) begin
         cs_d = line_level(1'b1);
      end else if (busy && !pkt_end) begin
         cs_d = line_level(1'b1);
      end else begin
         cs_d = line_level(1'b0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b1;
      end else begin
         cs_q <= cs_d;
      end
   end

   assign cs_n_o = cs_q;

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
   import spi_cs_seq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_mode,
   input  logic             sw_level,
   input  logic [CNT_W-1:0] gap_count,
   input  logic             pkt_start,
   input  logic             pkt_end,
   output logic             cs_n,
   output logic             ready
);

   logic      busy_q;
   sel_mode_e mode_q;
   sel_mode_e eff_mode;
   logic      gap_met;
   logic      start_acc;

   spi_cs_seq_mode u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_req  (auto_mode),
      .start_acc (start_acc),
      .pkt_end   (pkt_end),
      .busy_o    (busy_q),
      .mode_o    (mode_q),
      .eff_o     (eff_mode)
   );

   spi_cs_seq_gap #(.CNT_W(CNT_W)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_hi (cs_n),
      .gap_cfg (gap_count),
      .gap_met (gap_met)
   );

   spi_cs_seq_line u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .eff       (eff_mode),
      .start_acc (start_acc),
      .busy      (busy_q),
      .pkt_end   (pkt_end),
      .sw_level  (sw_level),
      .cs_n_o    (cs_n)
   );

   always_comb begin
      if (busy_q) begin
         ready = 1'b0;
      end else if (eff_mode == SEL_SW) begin
         ready = 1'b1;
      end else begin
         ready = cs_n && gap_met;
      end
      start_acc = pkt_start && ready;
   end

endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk
   import spi_cs_seq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             auto_mode,
   input logic             sw_level,
   input logic [CNT_W-1:0] gap_count,
   input logic             pkt_start,
   input logic             cs_n,
   input logic             ready,
   input logic             busy_q,
   input sel_mode_e        mode_q,
   input sel_mode_e        eff_mode
);

   localparam logic [CNT_W:0] HI_MAX = {(CNT_W+1){1'b1}};

   logic [CNT_W:0] hi_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_seen <= HI_MAX;
      end else if (!cs_n) begin
         hi_seen <= '0;
      end else if (hi_seen != HI_MAX) begin
         hi_seen <= hi_seen + 1'b1;
      end
   end

   AST_START_SELECTS: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_start && ready && auto_mode) |=> !cs_n); // R3

   AST_SW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode == SEL_SW) |=> (cs_n == $past(sw_level))); // R2

   AST_AUTO_READY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_mode && ready) |-> (cs_n && (({1'b0, hi_seen} + 1'b1) >= {2'b00, gap_count}))); // R5

   AST_ZERO_GAP_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_mode && !busy_q && cs_n && gap_count == '0) |-> ready); // R6

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> (mode_q == $past(mode_q))); // R7

   AST_DROP_START: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !busy_q) |=> !busy_q); // R8

   AST_SW_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (eff_mode == SEL_SW) |-> (ready == !busy_q)); // R9

endmodule

bind spi_cs_seq spi_cs_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .auto_mode (auto_mode),
   .sw_level  (sw_level),
   .gap_count (gap_count),
   .pkt_start (pkt_start),
   .cs_n      (cs_n),
   .ready     (ready),
   .busy_q    (busy_q),
   .mode_q    (mode_q),
   .eff_mode  (eff_mode)
);

// File: tb/spi_cs_seq_tb_top.sv
module spi_cs_seq_tb_top;

   localparam int CNT_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             auto_mode = 1'b0;
   logic             sw_level = 1'b1;
   logic [CNT_W-1:0] gap_count = '0;
   logic             pkt_start = 1'b0;
   logic             pkt_end = 1'b0;
   logic             cs_n;
   logic             ready;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   bit m_busy = 1'b0;
   bit m_auto = 1'b0;
   bit m_cs   = 1'b1;
   int m_high = 1 << 30;
   bit m_rdy;

   always #10 clk = ~clk;

   spi_cs_seq #(.CNT_W(CNT_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .auto_mode (auto_mode),
      .sw_level  (sw_level),
      .gap_count (gap_count),
      .pkt_start (pkt_start),
      .pkt_end   (pkt_end),
      .cs_n      (cs_n),
      .ready     (ready)
   );

   task automatic check(input bit cond, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!cond) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit eff_auto();
      return m_busy ? m_auto : auto_mode;
   endfunction

   function automatic bit exp_ready();
      if (m_busy) return 1'b0;
      if (!eff_auto()) return 1'b1;
      return m_cs && (m_high + 1 >= int'(gap_count));
   endfunction

   // inputs are set after a falling edge; compare, then advance model at the rising edge
   task automatic step(input string tag);
      string tc;
      string tr;
      bit    acc;
      bit    nxt;
      bit    ea;
      #2;
      m_rdy = exp_ready();
      ea = eff_auto();
      tc = (tag != "") ? tag : (ea ? "R3" : "R2");
      tr = (tag != "") ? tag : (ea ? "R5" : "R9");
      check(cs_n == m_cs, tc, "cs_n", cs_n, m_cs);
      check(ready == m_rdy, tr, "ready", ready, m_rdy);
      @(posedge clk);
      acc = pkt_start && m_rdy;
      if (!ea) nxt = sw_level;
      else if (acc) nxt = 1'b0;
      else if (m_busy && !pkt_end) nxt = 1'b0;
      else nxt = 1'b1;
      if (m_cs) m_high++;
      else m_high = 0;
      if (acc) m_busy = 1'b1;
      else if (pkt_end) m_busy = 1'b0;
      m_auto = ea;
      m_cs = nxt;
      @(negedge clk);
      pkt_start = 1'b0;
      pkt_end = 1'b0;
   endtask

   task automatic run_packet(input int len, input string tag);
      pkt_start = 1'b1;
      step(tag);
      for (int i = 0; i < len; i++) begin
         pkt_end = (i == len - 1) && m_busy;
         step(tag);
      end
   endtask

   bit done = 1'b0;

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: reset state
      check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
      check(ready == 1'b1, "R1", "ready after reset", ready, 1);
      @(negedge clk);

      // software mode level following
      sw_level = 1'b0; step("R2");
      sw_level = 1'b1; step("R2");
      sw_level = 1'b0; step("R2");
      step("R2");
      // software-mode packet: ready tracks busy
      run_packet(3, "R9");
      sw_level = 1'b1; step("R9");
      repeat (4) step("R2");

      // entering automatic mode after a long high stretch
      auto_mode = 1'b1;
      gap_count = 8'd3;
      step("R10");

      // automatic packet, then a start held while not ready
      run_packet(4, "R3");
      for (int i = 0; i < 5; i++) begin
         pkt_start = 1'b1;
         sw_level = i[0];
         step(m_rdy ? "R5" : "R8");
      end
      for (int i = 0; i < 6; i++) begin
         sw_level = i[0];
         pkt_end = m_busy && (i == 3);
         step("R4");
      end

      // zero gap, back to back packets
      gap_count = 8'd0;
      run_packet(2, "R6");
      run_packet(2, "R6");
      run_packet(1, "R6");
      step("R6");

      // mode change during an automatic packet
      gap_count = 8'd2;
      repeat (3) step("R5");
      pkt_start = 1'b1;
      step("R7");
      auto_mode = 1'b0;
      sw_level = 1'b1;
      step("R7");
      step("R7");
      pkt_end = 1'b1;
      step("R7");
      step("R7");
      sw_level = 1'b0;
      step("R2");

      // mixed stimulus
      for (int i = 0; i < 600; i++) begin
         pkt_start = ($urandom % 3) == 0;
         pkt_end = m_busy && (($urandom % 4) == 0);
         if (($urandom % 7) == 0) sw_level = ~sw_level;
         if (($urandom % 40) == 0) auto_mode = ~auto_mode;
         if (($urandom % 25) == 0) gap_count = 8'($urandom % 6);
         step("");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule